// File: doc/BRIEF.md
# VCO Feedback Divider Calculator

This block turns a requested VCO frequency and a reference frequency, both given in Hz, into the short register code that sets the feedback divider of a synthesizer's integer-N VCO. It also reports the VCO frequency that the chosen code actually produces. A single-cycle start strobe launches a computation. Inputs that are out of range are rejected at once. Legal inputs go through three passes of one shared bit-serial divider. The first two passes scale each frequency down to kHz. The third pass forms their ratio.

The ratio is clamped to a floor of 16. It is then encoded as an offset from 16 in a 3-bit code. A ratio too large for the code saturates the code at its top value and is flagged as an error. The results stay on the outputs until a later computation replaces them. Completion is marked by a one-cycle valid pulse or a one-cycle error pulse.

Top module: `vco_fbdiv_calc`

## Requirements
- R1: After reset, `fb_code` and `vco_hz` are 0, and `done_ok` and `done_err` are low.
- R2: A start whose target is below 384,000,000 Hz or above 660,000,000 Hz raises `done_err` in the cycle after the start edge, with `fb_code` = 0 and `vco_hz` = 0. Both limits themselves are accepted.
- R3: A start whose reference is above 40,000,000 Hz is rejected in the same way. A reference of exactly 40,000,000 Hz is accepted.
- R4: A start whose target is 0, or whose reference is below 1000 Hz (zero once scaled to kHz), is rejected in the same way without running the divider.
- R5: For an accepted start, n = floor(floor(tgt/1000) / floor(ref/1000)). When 16 <= n <= 23, `fb_code` = n - 16, `vco_hz` = ref * n, and `done_ok` pulses 3*32+1 clock edges after the start edge.
- R6: When n < 16, n is clamped to 16. This gives `fb_code` = 0, `vco_hz` = ref * 16 and a `done_ok` pulse.
- R7: When n > 23, `fb_code` saturates at 7, `vco_hz` = ref * 23, and `done_err` pulses with the same latency as in R5.
- R8: `done_ok` and `done_err` are never high together, and each lasts exactly one cycle.
- R9: A start strobe that arrives while a computation is running is ignored.
- R10: `fb_code` and `vco_hz` change only in a cycle where `done_ok` or `done_err` is high. At all other times they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled only when idle |
| ref_hz_i | input | 32 | Reference frequency in Hz |
| tgt_hz_i | input | 32 | Requested VCO frequency in Hz |
| fb_code | output | 3 | Feedback divider code (ratio - 16) |
| vco_hz | output | 32 | VCO frequency the code produces, in Hz |
| done_ok | output | 1 | One-cycle pulse: result is valid |
| done_err | output | 1 | One-cycle pulse: input rejected or code saturated |

## Verification
A wrong remainder or quotient bit in the shared divider shows up only at the end of the computation, 97 edges after the start. It appears as a wrong code, a wrong frequency, or a valid pulse where an error pulse was expected. A bad phase or count sequence moves the completion pulse away from its fixed cycle. A range check that is off by one shows up on the very next cycle, as a missing or extra error pulse at the 384 MHz, 660 MHz or 40 MHz boundary. The reference model predicts every output on every clock, so a divergence is reported in the cycle where it first appears.

// File: rtl/vco_fbdiv_calc.sv
module vco_fbdiv_calc #(
  parameter int FW     = 32,
  parameter int CW     = 3,
  parameter int OFFS   = 16,
  parameter int SCALE  = 1000,
  parameter int FMIN   = 384000000,
  parameter int FMAX   = 660000000,
  parameter int RMAX   = 40000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [FW-1:0] ref_hz_i,
  input  logic [FW-1:0] tgt_hz_i,
  output logic [CW-1:0] fb_code,
  output logic [FW-1:0] vco_hz,
  output logic          done_ok,
  output logic          done_err
);
  localparam int CODE_MAX = (1 << CW) - 1;
  localparam int NMAX     = OFFS + CODE_MAX;
  localparam int NW       = $clog2(NMAX + 1);
  localparam int CNT_W    = $clog2(FW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FW - 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_DONE} state_t;

  state_t        state;
  logic [1:0]    phase;
  logic [CNT_W-1:0] cnt;
  logic [FW:0]   rem;
  logic [FW-1:0] quo, dvs, ref_q, tkhz, ratio;

  logic [FW:0]   rem_sh, rem_nx;
  logic          ge;
  logic [FW-1:0] quo_nx;
  logic          bad_in, sat;
  logic [FW-1:0] nsel;
  logic [NW-1:0] nfin;

  assign rem_sh = {rem[FW-1:0], quo[FW-1]};
  assign ge     = rem_sh >= {1'b0, dvs};
  assign rem_nx = ge ? rem_sh - {1'b0, dvs} : rem_sh;
  assign quo_nx = {quo[FW-2:0], ge};

  assign bad_in = (ref_hz_i < FW'(SCALE)) || (tgt_hz_i == '0) ||
                  (tgt_hz_i < FW'(FMIN)) || (tgt_hz_i > FW'(FMAX)) ||
                  (ref_hz_i > FW'(RMAX));

  assign nsel = (ratio < FW'(OFFS)) ? FW'(OFFS) : ratio;
  assign sat  = nsel > FW'(NMAX);
  assign nfin = sat ? NW'(NMAX) : nsel[NW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= '0;
      cnt      <= '0;
      rem      <= '0;
      quo      <= '0;
      dvs      <= '0;
      ref_q    <= '0;
      tkhz     <= '0;
      ratio    <= '0;
      fb_code  <= '0;
      vco_hz   <= '0;
      done_ok  <= 1'b0;
      done_err <= 1'b0;
    end else begin
      done_ok  <= 1'b0;
      done_err <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            if (bad_in) begin
              done_err <= 1'b1;
              fb_code  <= '0;
              vco_hz   <= '0;
            end else begin
              ref_q <= ref_hz_i;
              quo   <= tgt_hz_i;
              rem   <= '0;
              dvs   <= FW'(SCALE);
              cnt   <= '0;
              phase <= 2'd0;
              state <= S_DIV;
            end
          end
        end
        S_DIV: begin
          rem <= rem_nx;
          quo <= quo_nx;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            cnt <= '0;
            rem <= '0;
            case (phase)
              2'd0: begin
                tkhz  <= quo_nx;
                quo   <= ref_q;
                dvs   <= FW'(SCALE);
                phase <= 2'd1;
              end
              2'd1: begin
                quo   <= tkhz;
                dvs   <= quo_nx;
                phase <= 2'd2;
              end
              default: begin
                ratio <= quo_nx;
                state <= S_DONE;
              end
            endcase
          end
        end
        default: begin
          fb_code  <= CW'(nfin - NW'(OFFS));
          vco_hz   <= ref_q * FW'(nfin);
          done_ok  <= !sat;
          done_err <= sat;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_err));

  // R8
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_err) |=> !done_ok);

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_ok && !done_err) |-> ($stable(fb_code) && $stable(vco_hz)));

  // R7
  sat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_err && fb_code != '0) |-> (fb_code == CW'(CODE_MAX)));

  // R9
  busy_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(ref_q));
endmodule

// File: tb/vco_fbdiv_calc_tb_top.sv
module vco_fbdiv_calc_tb_top;
  localparam int LAT = 3 * 32 + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ref_hz_i = '0;
  logic [31:0] tgt_hz_i = '0;
  logic [2:0]  fb_code;
  logic [31:0] vco_hz;
  logic        done_ok, done_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  longint m_code, m_vco, p_code, p_vco;
  bit m_ok, m_err, p_err;
  int m_cnt;

  always #5 clk = ~clk;

  vco_fbdiv_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ref_hz_i(ref_hz_i), .tgt_hz_i(tgt_hz_i),
    .fb_code(fb_code), .vco_hz(vco_hz),
    .done_ok(done_ok), .done_err(done_err)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 0; m_vco = 0; m_ok = 0; m_err = 0; m_cnt = 0;
    end else begin
      m_ok = 0; m_err = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_code = p_code; m_vco = p_vco;
          m_err = p_err; m_ok = !p_err;
        end
      end else if (start_i) begin
        longint r, t, n;
        r = ref_hz_i; t = tgt_hz_i;
        if (r < 1000 || t == 0 || t < 384000000 || t > 660000000 || r > 40000000) begin
          m_err = 1; m_code = 0; m_vco = 0;
        end else begin
          n = (t / 1000) / (r / 1000);
          if (n < 16) n = 16;
          p_err = (n > 23);
          if (n > 23) n = 23;
          p_code = n - 16;
          p_vco = r * n;
          m_cnt = LAT;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (fb_code !== m_code[2:0] || vco_hz !== m_vco[31:0] ||
        done_ok !== m_ok || done_err !== m_err) begin
      errors++;
      $display("FAIL %s cyc %0d: got code=%0d vco=%0d ok=%b err=%b exp code=%0d vco=%0d ok=%b err=%b",
               cur_req, cycles, fb_code, vco_hz, done_ok, done_err,
               m_code, m_vco, m_ok, m_err);
    end
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input string req, input longint r, input longint t, input int wait_cyc);
    cur_req = req;
    @(negedge clk);
    ref_hz_i = r[31:0]; tgt_hz_i = t[31:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    run("R5", 27000000, 594000000, LAT + 3);
    run("R5", 25000000, 460000000, LAT + 3);
    run("R5", 30000000, 500000000, LAT + 3);
    run("R2", 383999999, 383999999, 4);
    run("R2_low", 24000000, 384000000, LAT + 3);
    run("R2", 30000000, 660000001, 4);
    run("R2_high", 30000000, 660000000, LAT + 3);
    run("R3", 40000001, 500000000, 4);
    run("R3_edge", 40000000, 660000000, LAT + 3);
    run("R6", 40000000, 400000000, LAT + 3);
    run("R7", 20000000, 500000000, LAT + 3);
    run("R7", 1000, 400000000, LAT + 3);
    run("R4", 0, 500000000, 4);
    run("R4", 999, 500000000, 4);
    run("R4", 27000000, 0, 4);
    run("R9", 27000000, 540000000, 5);
    run("R9", 50000000, 100, LAT + 3);
    run("R10", 26000000, 600000000, 20);
    run("R10", 0, 0, LAT + 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule